// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Override

A parameterized parallel digital I/O port. Each pin has a direction bit, an output latch bit and a synchronized input sample. A small register bus reads and writes three registers: direction, latch and port. For every pin the block drives an output enable and an output value toward the pad, and it takes the pad input level back.

An attached peripheral can take a pin over through per-pin data and output-enable multiplexers. A pin changes owner only while the peripheral is enabled on that pin and also asserts its output enable there. An enabled peripheral that is not driving leaves the pin to the port. The raw pin input is always forwarded to the peripheral. The sampled level stays readable through the port register whoever owns the pin.

A parameter mask marks pins that do not exist on this instance. Those bits read as zero in every register, and their pins are never driven.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset, every implemented direction bit reads 1 (input), the latch reads all zeros, and no pin output enable is asserted.
- R2: Register address 0 holds the direction. A direction bit of 1 makes the pin an input (pin_oe low). A bit of 0 makes it an output (pin_oe high), driving the latch bit on pin_out. A write takes effect on the clock edge that samples the strobe.
- R3: A read at address 1 returns the latch contents, not the pin levels.
- R4: A read at address 2 returns the pin input levels through a two-flop synchronizer, so a pin change appears on the second clock edge after it.
- R5: A write at address 2 updates the latch exactly as a write at address 1 does.
- R6: When per_en and per_oe are both 1 for a pin, pin_oe is 1 and pin_out equals per_dout on that pin. The latch and direction bits have no effect on it.
- R7: When per_en is 1 but per_oe is 0, or per_oe is 1 but per_en is 0, the port's direction and latch bits control the pin.
- R8: The port register reflects pin input levels while a peripheral owns the pin output.
- R9: Bits cleared in IMPL_MASK read as zero at addresses 0, 1 and 2, and their pin_oe and pin_out are always 0.
- R10: per_din equals pin_in at all times, with no added latency, whoever owns the pin.
- R11: Address 3 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 port, 3 reserved |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the addressed register (combinational) |
| pin_in | input | WIDTH | Pad input levels |
| pin_oe | output | WIDTH | Pad output enables |
| pin_out | output | WIDTH | Pad output values |
| per_en | input | WIDTH | Peripheral enabled, per pin |
| per_oe | input | WIDTH | Peripheral output enable, per pin |
| per_dout | input | WIDTH | Peripheral output data, per pin |
| per_din | output | WIDTH | Pin input forwarded to the peripheral |

## Verification
A wrong direction or latch bit shows on pin_oe or pin_out in the cycle after the write that should have set it. It also shows at once on a read of that register. A faulty ownership multiplexer shows up combinationally: with the peripheral enabled, the pin takes the wrong driver as soon as per_oe toggles. A synchronizer that is too short or too long shows up as a port read that changes one cycle early or late after a pin step. Writes routed to the wrong register, and reserved-address writes that leak through, show up on the next read-back.

// File: rtl/gpio_shared_port.sv
module gpio_shared_port #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  input  logic [WIDTH-1:0] per_en,
  input  logic [WIDTH-1:0] per_oe,
  input  logic [WIDTH-1:0] per_dout,
  output logic [WIDTH-1:0] per_din
);
  localparam logic [1:0] A_DIR = 2'd0, A_LAT = 2'd1, A_PORT = 2'd2;

  logic [WIDTH-1:0] dir_q, lat_q, sync1_q, sync2_q;
  logic [WIDTH-1:0] owned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DIR) dir_q <= bus_wdata & IMPL_MASK;
      if (bus_addr == A_LAT || bus_addr == A_PORT) lat_q <= bus_wdata & IMPL_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign owned   = per_en & per_oe;
  assign pin_oe  = IMPL_MASK & (owned | ~dir_q);
  assign pin_out = IMPL_MASK & ((owned & per_dout) | (~owned & lat_q));
  assign per_din = pin_in;

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q & IMPL_MASK;
      A_LAT:   bus_rdata = lat_q & IMPL_MASK;
      A_PORT:  bus_rdata = sync2_q & IMPL_MASK;
      default: bus_rdata = '0;
    endcase
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (dir_q == ($past(bus_wdata) & IMPL_MASK)));

  assert_port_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PORT) |=> (lat_q == ($past(bus_wdata) & IMPL_MASK)));

  assert_latch_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || bus_addr == 2'd3) |=> $stable(lat_q) && $stable(dir_q));

  assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (sync2_q == $past(pin_in, 2)));

  assert_owner_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((owned & IMPL_MASK) & ~pin_oe) == '0) &&
    (((owned & IMPL_MASK) & (pin_out ^ per_dout)) == '0));

  assert_unimpl_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out) & ~IMPL_MASK) == '0);
endmodule

// File: tb/tb_gpio_shared_port.sv
module tb_gpio_shared_port;
  localparam int W = 8;
  localparam logic [W-1:0] MASK = 8'h7F;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_oe, pin_out;
  logic [W-1:0] per_en = 0, per_oe = 0, per_dout = 0, per_din;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_shared_port #(.WIDTH(W), .IMPL_MASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .per_en(per_en), .per_oe(per_oe),
    .per_dout(per_dout), .per_din(per_din));

  typedef struct packed {
    logic [7:0] dir, lat, pen, poe, pdo, eoe, eout;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hFF, 8'hAA, 8'h00, 8'h00, 8'h00, 8'h00, 8'h2A},
    '{8'h00, 8'h55, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h55},
    '{8'hF0, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h0F},
    '{8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h05, 8'h7F, 8'h75},
    '{8'hFF, 8'h00, 8'h0F, 8'hFF, 8'hFF, 8'h0F, 8'h0F},
    '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h7F},
    '{8'h0F, 8'h3C, 8'hF0, 8'h00, 8'hFF, 8'h70, 8'h3C},
    '{8'h80, 8'h80, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h00}
  };

  task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [W-1:0] r;
    repeat (3) @(posedge clk);
    #1;
    bus_read(2'd0, r); check("R1", "direction after reset", r, MASK);
    bus_read(2'd1, r); check("R1", "latch after reset", r, 8'h00);
    check("R1", "pin_oe after reset", pin_oe, 8'h00);
    @(negedge clk); rst_n = 1;
    #1;
    bus_read(2'd0, r); check("R1", "direction after reset released", r, MASK);

    // Vector table: R2 R5 R6 R7 R9
    for (int i = 0; i < 8; i++) begin
      bus_write(2'd0, VECS[i].dir);
      bus_write((i % 2 == 0) ? 2'd1 : 2'd2, VECS[i].lat);
      per_en = VECS[i].pen; per_oe = VECS[i].poe; per_dout = VECS[i].pdo;
      #1;
      bus_read(2'd0, r); check("R2/R9", $sformatf("vec %0d dir readback", i), r, VECS[i].dir & MASK);
      bus_read(2'd1, r); check("R5/R9", $sformatf("vec %0d latch readback", i), r, VECS[i].lat & MASK);
      check("R6/R7", $sformatf("vec %0d pin_oe", i), pin_oe, VECS[i].eoe);
      check("R6/R7", $sformatf("vec %0d pin_out", i), pin_out, VECS[i].eout);
    end
    per_en = 0; per_oe = 0; per_dout = 0;

    // R4: two-edge synchronizer latency on port reads
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); pin_in = 8'hA5;
    @(posedge clk); #1;
    bus_read(2'd2, r); check("R4", "port one edge after step", r, 8'h00);
    @(posedge clk); #1;
    bus_read(2'd2, r); check("R4", "port two edges after step", r, 8'h25);
    check("R9", "unimplemented port bit reads zero", r & ~MASK, 8'h00);

    // R3: latch read differs from pin levels
    bus_write(2'd1, 8'h11);
    @(negedge clk); pin_in = 8'h22;
    repeat (3) @(posedge clk); #1;
    bus_read(2'd1, r); check("R3", "latch read ignores pins", r, 8'h11);

    // R8 and R10 with the peripheral owning every pin
    per_en = 8'hFF; per_oe = 8'hFF; per_dout = 8'h5A;
    @(negedge clk); pin_in = 8'h3C; #1;
    check("R10", "per_din follows pin_in at once", per_din, 8'h3C);
    check("R6", "owned pins drive peripheral data", pin_out, 8'h5A);
    repeat (2) @(posedge clk); #1;
    bus_read(2'd2, r); check("R8", "port readable while owned", r, 8'h3C);
    @(negedge clk); pin_in = 8'hC3; #1;
    check("R10", "per_din follows second level", per_din, 8'hC3);
    per_en = 0; per_oe = 0;

    // R11: reserved address
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, r); check("R11", "reserved address reads zero", r, 8'h00);
    bus_read(2'd1, r); check("R11", "latch unchanged by reserved write", r, 8'h11);
    bus_read(2'd0, r); check("R11", "direction unchanged by reserved write", r, 8'h00);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule